// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

This block collects up to eight interrupt request lines from peripherals, ranks them by fixed priority and signals a processor through a single interrupt output. The processor answers with a one-cycle acknowledge pulse. In that same cycle the block places an 8-bit vector on its output and moves the winning request into its in-service register. Software later retires the level with a specific end-of-interrupt command, unless the controller was set up to retire levels by itself at acknowledge time.

Software reaches the block through two byte-wide ports picked by one address bit: a command port (address 0) and a data port (address 1). A fixed command byte starts a three-word setup sequence on the data port. That sequence sets the vector base, the cascade word and the option word. After setup, data-port traffic goes to the mask register. Other command bytes choose which status register a command-port read returns, or retire one in-service level. A pin selects master or slave behaviour, so one design can sit at either end of a two-level cascade.

Top module: `intc8_core`

## Requirements
- R1: Reset leaves the mask at 0xFF and the request and in-service registers at zero. Command-port reads select the request register, the vector base is zero, `int_out` is low, and the first data-port read returns 0xFF.
- R2: Writing 0x11 to the command port starts setup. The next three data-port writes load the vector base, the cascade word and the option word, in that order, and none of them changes the mask. `int_out` stays low from the start command until the third word has been written.
- R3: While `inta` is high, `vector` equals the vector base plus the level being acknowledged, modulo 256. While `inta` is low, `vector` is zero.
- R4: A rising edge on `irq_in[n]` sets request bit n. The bit clears when the line is low at a clock edge, or when level n is acknowledged.
- R5: Outside setup, a data-port write loads the mask and a data-port read returns it. A set mask bit stops that request from raising `int_out`.
- R6: Priority is fixed, with line 0 highest. `int_out` is high exactly when setup is not in progress and the lowest-numbered unmasked pending request is lower-numbered than every in-service level.
- R7: With auto-retire off, an acknowledge sets the in-service bit of the winning level and clears its request bit.
- R8: Bit 1 of the option word turns auto-retire on. When it is on, an acknowledge sets no in-service bit.
- R9: Command byte 0x0A makes later command-port reads return the request register, and 0x0B makes them return the in-service register. The choice holds until it is changed.
- R10: Command byte 0x60+n, for n from 0 to 7, clears in-service bit n and no other bit.
- R11: If no request qualifies under R6 when `inta` is high, the vector is the base plus 7 and no in-service bit changes. This holds even when line 7 is masked.
- R12: In master mode (`master_sel`=1), if the acknowledged level has its bit set in the cascade word, `cas_out` shows that level and `vec_en` is low. Otherwise `vec_en` is high and `cas_out` is zero. In slave mode, `vec_en` is high during `inta` only when `cas_in` equals bits 2:0 of the cascade word.
- R13: Command bytes that match none of 0x11, 0x0A, 0x0B or 0x60 to 0x67 change nothing. A new 0x11 at any time clears the in-service register and selects the request register for command-port reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_sel | input | 1 | 1 = master cascade role, 0 = slave role |
| cas_in | input | 3 | Slave-select code from the master (slave role) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 = command port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (zero when rd_en is low) |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | One-cycle acknowledge |
| vector | output | 8 | Vector, valid while inta is high |
| vec_en | output | 1 | This controller drives the vector |
| cas_out | output | 3 | Cascade line being acknowledged (master role) |

## Verification
The hardest case to reach is the spurious acknowledge. A request has to raise `int_out` and then disappear before the processor answers. The stimulus pulses a line high for one edge, drops it one cycle before `inta`, and masks line 7 at the same time, so a level-7 answer cannot come from a real request. A second hard case is a setup restart while a level is in service and the status selection points at the in-service register. The stimulus builds that state on purpose, then checks that the restart clears both.

// File: rtl/intc8_pkg.sv
package intc8_pkg;
  localparam int PIC_LINES = 8;
  localparam int PIC_LW    = $clog2(PIC_LINES);
  localparam int PIC_DW    = 8;

  localparam logic [PIC_DW-1:0] CMD_SETUP   = 8'h11;
  localparam logic [PIC_DW-1:0] CMD_SEL_REQ = 8'h0A;
  localparam logic [PIC_DW-1:0] CMD_SEL_SVC = 8'h0B;
  localparam logic [PIC_DW-1:0] CMD_RETIRE  = 8'h60;
  localparam logic [PIC_DW-1:0] RETIRE_MASK = 8'hF8;
  localparam int OPT_AUTO_BIT = 1;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_BASE, SEQ_CASC, SEQ_OPT} seq_e;
  typedef enum logic {RSEL_REQ, RSEL_SVC} rsel_e;

  // Lowest set index, with a found flag in the top bit
  function automatic logic [PIC_LW:0] first_set(input logic [PIC_LINES-1:0] v);
    logic [PIC_LW:0] r;
    r = '0;
    for (int i = PIC_LINES - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, PIC_LW'(i)};
    end
    return r;
  endfunction

  function automatic logic [PIC_LINES-1:0] lvl_bit(input logic [PIC_LW-1:0] l);
    return PIC_LINES'(1) << l;
  endfunction

  function automatic logic [PIC_DW-1:0] vec_of(input logic [PIC_DW-1:0] base,
                                               input logic [PIC_LW-1:0] l);
    return base + PIC_DW'(l);
  endfunction
endpackage

// File: rtl/intc8_prog.sv
module intc8_prog
  import intc8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [PIC_DW-1:0] wdata,
  output logic [PIC_DW-1:0] imr,
  output logic [PIC_DW-1:0] base,
  output logic [PIC_DW-1:0] casc,
  output logic              auto_ret,
  output rsel_e             rsel,
  output logic              init_busy,
  output logic              init_start,
  output logic              eoi_pulse,
  output logic [PIC_LW-1:0] eoi_lvl
);
  seq_e seq;
  logic cmd_wr, dat_wr;

  assign cmd_wr     = wr_en && !addr;
  assign dat_wr     = wr_en && addr;
  assign init_start = cmd_wr && (wdata == CMD_SETUP);
  assign eoi_pulse  = cmd_wr && ((wdata & RETIRE_MASK) == CMD_RETIRE);
  assign eoi_lvl    = wdata[PIC_LW-1:0];
  assign init_busy  = (seq != SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq      <= SEQ_IDLE;
      imr      <= '1;
      base     <= '0;
      casc     <= '0;
      auto_ret <= 1'b0;
      rsel     <= RSEL_REQ;
    end else if (init_start) begin
      seq  <= SEQ_BASE;
      rsel <= RSEL_REQ;
    end else begin
      if (cmd_wr && wdata == CMD_SEL_REQ) rsel <= RSEL_REQ;
      if (cmd_wr && wdata == CMD_SEL_SVC) rsel <= RSEL_SVC;
      if (dat_wr) begin
        case (seq)
          SEQ_BASE: begin base <= wdata; seq <= SEQ_CASC; end
          SEQ_CASC: begin casc <= wdata; seq <= SEQ_OPT;  end
          SEQ_OPT:  begin auto_ret <= wdata[OPT_AUTO_BIT]; seq <= SEQ_IDLE; end
          default:  imr <= wdata;
        endcase
      end
    end
  end
endmodule

// File: rtl/intc8_req.sv
module intc8_req
  import intc8_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIC_LINES-1:0] irq_in,
  input  logic [PIC_LINES-1:0] ack_clr,
  output logic [PIC_LINES-1:0] irr
);
  logic [PIC_LINES-1:0] prev;

  for (genvar g = 0; g < PIC_LINES; g++) begin : g_line
    logic rise;
    assign rise = irq_in[g] && !prev[g];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev[g] <= 1'b0;
        irr[g]  <= 1'b0;
      end else begin
        prev[g] <= irq_in[g];
        irr[g]  <= (irr[g] || rise) && irq_in[g] && !ack_clr[g];
      end
    end
  end
endmodule

// File: rtl/intc8_resolve.sv
module intc8_resolve
  import intc8_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIC_LINES-1:0] irr,
  input  logic [PIC_DW-1:0]    imr,
  input  logic [PIC_DW-1:0]    base,
  input  logic [PIC_DW-1:0]    casc,
  input  logic                 auto_ret,
  input  logic                 init_busy,
  input  logic                 init_start,
  input  logic                 eoi_pulse,
  input  logic [PIC_LW-1:0]    eoi_lvl,
  input  logic                 inta,
  input  logic                 master_sel,
  input  logic [PIC_LW-1:0]    cas_in,
  output logic                 int_out,
  output logic [PIC_DW-1:0]    vector,
  output logic                 vec_en,
  output logic [PIC_LW-1:0]    cas_out,
  output logic [PIC_LINES-1:0] isr,
  output logic [PIC_LINES-1:0] ack_clr,
  output logic                 ack_real,
  output logic [PIC_LW-1:0]    ack_lvl
);
  logic [PIC_LW:0]      pend_f, svc_f;
  logic                 eligible, slave_line;
  logic [PIC_LINES-1:0] isr_nx;

  assign pend_f   = first_set(irr & ~imr[PIC_LINES-1:0]);
  assign svc_f    = first_set(isr);
  assign eligible = pend_f[PIC_LW] &&
                    (!svc_f[PIC_LW] || pend_f[PIC_LW-1:0] < svc_f[PIC_LW-1:0]);
  assign int_out  = eligible && !init_busy;

  assign ack_real   = inta && eligible;
  assign ack_lvl    = ack_real ? pend_f[PIC_LW-1:0] : PIC_LW'(PIC_LINES - 1);
  assign ack_clr    = ack_real ? lvl_bit(ack_lvl) : '0;
  assign slave_line = master_sel && casc[ack_lvl];
  assign vector     = inta ? vec_of(base, ack_lvl) : '0;
  assign cas_out    = (inta && slave_line) ? ack_lvl : '0;
  assign vec_en     = inta && (master_sel ? !casc[ack_lvl]
                                          : (cas_in == casc[PIC_LW-1:0]));

  always_comb begin
    isr_nx = isr;
    if (eoi_pulse) isr_nx = isr_nx & ~lvl_bit(eoi_lvl);
    if (ack_real && !auto_ret) isr_nx = isr_nx | lvl_bit(ack_lvl);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          isr <= '0;
    else if (init_start) isr <= '0;
    else                 isr <= isr_nx;
  end
endmodule

// File: rtl/intc8_core.sv
module intc8_core
  import intc8_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 master_sel,
  input  logic [PIC_LW-1:0]    cas_in,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic                 addr,
  input  logic [PIC_DW-1:0]    wdata,
  output logic [PIC_DW-1:0]    rdata,
  input  logic [PIC_LINES-1:0] irq_in,
  output logic                 int_out,
  input  logic                 inta,
  output logic [PIC_DW-1:0]    vector,
  output logic                 vec_en,
  output logic [PIC_LW-1:0]    cas_out
);
  logic [PIC_DW-1:0]    imr, base, casc;
  logic                 auto_ret, init_busy, init_start, eoi_pulse, ack_real;
  logic [PIC_LW-1:0]    eoi_lvl, ack_lvl;
  logic [PIC_LINES-1:0] irr, isr, ack_clr;
  rsel_e                rsel;

  intc8_prog u_prog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .imr(imr), .base(base), .casc(casc), .auto_ret(auto_ret), .rsel(rsel),
    .init_busy(init_busy), .init_start(init_start),
    .eoi_pulse(eoi_pulse), .eoi_lvl(eoi_lvl)
  );

  intc8_req u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_clr(ack_clr), .irr(irr)
  );

  intc8_resolve u_res (
    .clk(clk), .rst_n(rst_n), .irr(irr), .imr(imr), .base(base), .casc(casc),
    .auto_ret(auto_ret), .init_busy(init_busy), .init_start(init_start),
    .eoi_pulse(eoi_pulse), .eoi_lvl(eoi_lvl), .inta(inta),
    .master_sel(master_sel), .cas_in(cas_in), .int_out(int_out),
    .vector(vector), .vec_en(vec_en), .cas_out(cas_out), .isr(isr),
    .ack_clr(ack_clr), .ack_real(ack_real), .ack_lvl(ack_lvl)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr)                  rdata = imr;
      else if (rsel == RSEL_SVC) rdata = PIC_DW'(isr);
      else                       rdata = PIC_DW'(irr);
    end
  end
endmodule

// File: rtl/intc8_core_chk.sv
module intc8_core_chk
  import intc8_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 inta,
  input logic                 int_out,
  input logic                 init_start,
  input logic                 init_busy,
  input logic                 eoi_pulse,
  input logic [PIC_LW-1:0]    eoi_lvl,
  input logic                 ack_real,
  input logic [PIC_LW-1:0]    ack_lvl,
  input logic [PIC_LINES-1:0] isr,
  input logic [PIC_LINES-1:0] irr,
  input logic [PIC_DW-1:0]    imr,
  input logic                 auto_ret
);
  assert_int_needs_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> |(irr & ~imr[PIC_LINES-1:0]));

  assert_quiet_in_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> !int_out);

  assert_ack_to_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_real && !auto_ret && !init_start) |=> isr[$past(ack_lvl)]);

  assert_auto_keeps_svc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && auto_ret && !eoi_pulse && !init_start) |=> (isr == $past(isr)));

  assert_spurious_no_svc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !ack_real && !eoi_pulse && !init_start) |=> (isr == $past(isr)));

  assert_retire_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_pulse && !ack_real && !init_start) |=> !isr[$past(eoi_lvl)]);

  assert_restart_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> (isr == '0));
endmodule

bind intc8_core intc8_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .inta(inta), .int_out(int_out),
  .init_start(init_start), .init_busy(init_busy), .eoi_pulse(eoi_pulse),
  .eoi_lvl(eoi_lvl), .ack_real(ack_real), .ack_lvl(ack_lvl), .isr(isr),
  .irr(irr), .imr(imr), .auto_ret(auto_ret)
);

// File: tb/intc8_core_tb.sv
module intc8_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master_sel = 1'b1;
  logic [2:0] cas_in = 3'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, inta = 1'b0;
  logic [7:0] wdata = 8'h00, irq_in = 8'h00;
  logic [7:0] rdata, vector;
  logic       int_out, vec_en;
  logic [2:0] cas_out;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural model state
  bit [7:0] m_prev, m_irr, m_isr, m_imr, m_base, m_casc;
  bit       m_auto, m_sel_svc;
  int       m_step;

  always #4 clk = ~clk;

  intc8_core u_dut (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .cas_in(cas_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_in(irq_in), .int_out(int_out), .inta(inta), .vector(vector),
    .vec_en(vec_en), .cas_out(cas_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int m_win();
    int top_svc = 8;
    for (int i = 7; i >= 0; i--) if (m_isr[i]) top_svc = i;
    for (int i = 0; i < top_svc; i++) if (m_irr[i] && !m_imr[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    int w;
    if (!rst_n) begin
      m_prev = 0; m_irr = 0; m_isr = 0; m_imr = 8'hFF; m_base = 0;
      m_casc = 0; m_auto = 0; m_sel_svc = 0; m_step = 0;
    end else begin
      w = m_win();
      if (wr_en && !addr && wdata == 8'h11) begin
        m_isr = 0; m_sel_svc = 0; m_step = 1;
      end else begin
        if (wr_en && !addr && wdata == 8'h0A) m_sel_svc = 0;
        if (wr_en && !addr && wdata == 8'h0B) m_sel_svc = 1;
        if (wr_en && !addr && wdata >= 8'h60 && wdata <= 8'h67) m_isr[wdata - 8'h60] = 0;
        if (inta && w >= 0 && !m_auto) m_isr[w] = 1;
        if (wr_en && addr) begin
          if (m_step == 1) begin m_base = wdata; m_step = 2; end
          else if (m_step == 2) begin m_casc = wdata; m_step = 3; end
          else if (m_step == 3) begin m_auto = wdata[1]; m_step = 0; end
          else m_imr = wdata;
        end
      end
      for (int i = 0; i < 8; i++) begin
        if (inta && w == i) m_irr[i] = 0;
        else m_irr[i] = (m_irr[i] || (irq_in[i] && !m_prev[i])) && irq_in[i];
      end
      m_prev = irq_in;
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    int w, lvl, e_rd, e_vec, e_en, e_cas;
    #2;
    if (rst_n && !done) begin
      w = m_win();
      chk("R6 int_out", int_out, (w >= 0 && m_step == 0) ? 1 : 0);
      e_rd = !rd_en ? 0 : addr ? m_imr : m_sel_svc ? m_isr : m_irr;
      chk("R9 rdata", rdata, e_rd);
      lvl = (w >= 0) ? w : 7;
      e_vec = inta ? ((m_base + lvl) % 256) : 0;
      e_en  = !inta ? 0 : master_sel ? !m_casc[lvl] : (cas_in == m_casc[2:0]);
      e_cas = (inta && master_sel && m_casc[lvl]) ? lvl : 0;
      chk("R3 vector", vector, e_vec);
      chk("R12 vec_en", vec_en, e_en);
      chk("R12 cas_out", cas_out, e_cas);
    end
  end

  task automatic wr(input bit a, input bit [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input bit a, input int exp, input string tag);
    @(negedge clk); rd_en = 1; addr = a;
    #2 chk(tag, rdata, exp);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic see_int(input int exp, input string tag);
    @(negedge clk); #2 chk(tag, int_out, exp);
  endtask

  task automatic line(input int i, input bit v);
    @(negedge clk); irq_in[i] = v;
  endtask

  task automatic ack(input int e_vec, input int e_en, input int e_cas, input string tag);
    @(negedge clk); inta = 1;
    #2;
    chk(tag, vector, e_vec);
    chk({tag, " en"}, vec_en, e_en);
    chk({tag, " cas"}, cas_out, e_cas);
    @(negedge clk); inta = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(1, 8'hFF, "R1 mask");
    rd(0, 8'h00, "R1 request");
    see_int(0, "R1 int_out");
    // R2 setup: base 0x40, line 2 has a slave, no auto-retire
    wr(0, 8'h11);
    wr(1, 8'h40);
    wr(1, 8'h04);
    rd(1, 8'hFF, "R2 mask untouched");
    wr(1, 8'h00);
    // R5 unmask
    wr(1, 8'h00);
    rd(1, 8'h00, "R5 mask read");
    // R4 edge sets request
    line(5, 1);
    see_int(1, "R4 int_out");
    rd(0, 8'h20, "R4 request");
    line(3, 1);
    ack(8'h43, 1, 0, "R6 priority");
    wr(0, 8'h0B);
    rd(0, 8'h08, "R7 in-service");
    see_int(0, "R6 blocked");
    rd(0, 8'h08, "R9 persists");
    wr(0, 8'h63);
    see_int(1, "R10 after retire");
    ack(8'h45, 1, 0, "R3 vector");
    line(1, 1);
    ack(8'h41, 1, 0, "R6 preempt");
    rd(0, 8'h22, "R7 nested");
    wr(0, 8'h65);
    rd(0, 8'h02, "R10 only n");
    wr(0, 8'h61);
    rd(0, 8'h00, "R10 cleared");
    // R12 cascade line in master mode
    line(2, 1);
    ack(8'h42, 0, 2, "R12 master");
    // R13 unrecognised command
    wr(0, 8'h20);
    rd(0, 8'h04, "R13 ignored svc");
    rd(1, 8'h00, "R13 ignored mask");
    // R11 spurious with line 7 masked
    line(1, 0); line(2, 0); line(3, 0); line(5, 0);
    wr(1, 8'h80);
    line(0, 1);
    see_int(1, "R11 raised");
    line(0, 0);
    ack(8'h47, 1, 0, "R11 spurious");
    rd(0, 8'h04, "R11 svc kept");
    // R13 restart clears service and selection; R2 int held low
    wr(0, 8'h11);
    line(1, 1);
    see_int(0, "R2 held");
    rd(0, 8'h02, "R13 select reset");
    wr(1, 8'h80);
    wr(1, 8'h00);
    see_int(0, "R2 still held");
    wr(1, 8'h02);
    see_int(1, "R2 released");
    // R8 auto-retire
    ack(8'h81, 1, 0, "R8 vector");
    wr(0, 8'h0B);
    rd(0, 8'h00, "R8 no svc");
    // R12 slave role, id 5
    master_sel = 0;
    line(1, 0);
    wr(0, 8'h11);
    wr(1, 8'h20);
    wr(1, 8'h05);
    wr(1, 8'h00);
    cas_in = 3'd3;
    line(6, 1);
    ack(8'h26, 0, 0, "R12 slave other");
    wr(0, 8'h66);
    line(6, 0);
    cas_in = 3'd5;
    line(6, 1);
    ack(8'h26, 1, 0, "R12 slave match");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule